// File: doc/BRIEF.md
# Super I/O Configuration Port

This block models the device side of the configuration interface of a multi-function I/O chip. Software reaches it through two byte-wide ports on a simple synchronous bus: an index port and a data port, chosen by one address bit. The configuration space starts closed. Two back-to-back key bytes written to the index port open it, and an exit byte written to the same port closes it again. While the space is open, software writes a register number to the index port and then reads or writes that register through the data port.

Register 0x07 is global and chooses a logical device. The device-specific registers at higher numbers then address that device's own bank. Each bank has an activate flag, two 16-bit base addresses, an IRQ number and a trigger-type byte. Two logical devices also carry one direction register per GPIO pin. The block drives these directions straight out on `gpio_dir`, so the pin logic around it can use them. The peripherals behind the logical devices are not part of this block.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the block is locked, `rdata` is 0xFF, every bit of `gpio_dir` is 1 (input), and every logical device reads back inactive (register 0x30 = 0x00).
- R2: Two consecutive index-port writes of the key 0x87 while locked open the configuration space.
- R3: While locked, an index-port write of any value other than 0x87 restarts the key count. The sequence 0x87, other, 0x87 leaves the block locked.
- R4: While open, an index-port write of 0xAA locks the block. It does not change the stored index.
- R5: While locked, data-port writes change no register, and reads from either port return 0xFF.
- R6: Register 0x07 holds the selected logical device (0..8). Bank registers of different devices are independent. With a selection of 9 or above, bank reads return 0x00 and bank writes are ignored.
- R7: Register 0x30 stores only bit 0, the device activate flag. Reads return {7'b0, flag}.
- R8: Registers 0x60/0x61 and 0x62/0x63 hold two 16-bit base addresses. The high byte is at the even number and the low byte at the odd number. Each byte reads back as written.
- R9: Register 0x70 holds the IRQ number and 0x71 the trigger type (for example 0x02 = edge, active high). Both are stored as full bytes.
- R10: In device 7, registers 0xE1..0xE7 hold bit 0 of `gpio_dir[0..6]`. In device 8, registers 0xE8..0xEB hold bit 0 of `gpio_dir[7..10]`. A 1 means input and a 0 means output. Reads return {7'b0, dir}. The same numbers in any other device, and 0xEC in device 8, do not touch `gpio_dir`. Unimplemented registers read 0x00.
- R11: `rdata` is registered. It shows the value from one cycle after a `rd_en` strobe, taken from the state before any write in that same cycle. It holds its value when `rd_en` is low.
- R12: While open, an index-port read returns the stored register number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr_sel | input | 1 | 0 = index port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| gpio_dir | output | 11 | GPIO directions, 1 = input |

## Verification
A read strobe and a write strobe can fall in the same cycle on the same port. The bench provokes this in two ways. First, it writes a new IRQ value while reading the data port. Second, it writes the exit byte while reading the index port. In each case the read must return the value from before the write: the old IRQ number, or the stored index rather than 0xFF. A follow-up read then confirms the write took effect, showing the new IRQ value in one case and 0xFF in the locked case.

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter int          NUM_LDEV = 9,
  parameter logic [7:0]  KEY      = 8'h87,
  parameter logic [7:0]  EXIT     = 8'hAA,
  parameter int          GPA_DEV  = 7,
  parameter int          GPB_DEV  = 8,
  parameter int          GPA_PINS = 7,
  parameter int          GPB_PINS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic                           addr_sel,
  input  logic [7:0]                     wdata,
  output logic [7:0]                     rdata,
  output logic [GPA_PINS+GPB_PINS-1:0]   gpio_dir
);
  localparam int         GPIO_N    = GPA_PINS + GPB_PINS;
  localparam int         GPW       = $clog2(GPIO_N);
  localparam int         LW        = $clog2(NUM_LDEV);
  localparam logic [7:0] GPA_FIRST = 8'hE1;
  localparam logic [7:0] GPB_FIRST = GPA_FIRST + 8'(GPA_PINS);
  localparam logic [7:0] GPB_END   = GPB_FIRST + 8'(GPB_PINS);

  logic              open_q, half_q;
  logic [7:0]        idx_q, sel_q;
  logic [NUM_LDEV-1:0] act_q;
  logic [7:0]        base_q [NUM_LDEV][4];
  logic [7:0]        irq_q  [NUM_LDEV];
  logic [7:0]        trig_q [NUM_LDEV];
  logic [GPIO_N-1:0] dir_q;

  logic              idx_wr, dat_wr, sel_ok, gp_hit;
  logic [LW-1:0]     ld;
  logic [GPW-1:0]    gp_bit;
  logic [7:0]        cfg_val;

  assign idx_wr   = wr_en & ~addr_sel;
  assign dat_wr   = wr_en & addr_sel & open_q;
  assign sel_ok   = sel_q < 8'(NUM_LDEV);
  assign ld       = sel_q[LW-1:0];
  assign gpio_dir = dir_q;

  always_comb begin
    gp_hit = 1'b0;
    gp_bit = '0;
    if (sel_q == 8'(GPA_DEV) && idx_q >= GPA_FIRST && idx_q < GPB_FIRST) begin
      gp_hit = 1'b1;
      gp_bit = GPW'(idx_q - GPA_FIRST);
    end else if (sel_q == 8'(GPB_DEV) && idx_q >= GPB_FIRST && idx_q < GPB_END) begin
      gp_hit = 1'b1;
      gp_bit = GPW'(idx_q - GPB_FIRST + 8'(GPA_PINS));
    end
  end

  always_comb begin
    cfg_val = 8'h00;
    case (idx_q)
      8'h07: cfg_val = sel_q;
      8'h30: if (sel_ok) cfg_val = {7'b0, act_q[ld]};
      8'h60, 8'h61, 8'h62, 8'h63: if (sel_ok) cfg_val = base_q[ld][idx_q[1:0]];
      8'h70: if (sel_ok) cfg_val = irq_q[ld];
      8'h71: if (sel_ok) cfg_val = trig_q[ld];
      default: if (gp_hit) cfg_val = {7'b0, dir_q[gp_bit]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      half_q <= 1'b0;
      idx_q  <= 8'h00;
      sel_q  <= 8'h00;
      act_q  <= '0;
      dir_q  <= '1;
      rdata  <= 8'hFF;
      for (int d = 0; d < NUM_LDEV; d++) begin
        irq_q[d]  <= 8'h00;
        trig_q[d] <= 8'h00;
        for (int b = 0; b < 4; b++) base_q[d][b] <= 8'h00;
      end
    end else begin
      if (rd_en)
        rdata <= !open_q ? 8'hFF : (addr_sel ? cfg_val : idx_q);
      if (idx_wr) begin
        if (open_q) begin
          if (wdata == EXIT) begin
            open_q <= 1'b0;
            half_q <= 1'b0;
          end else begin
            idx_q <= wdata;
          end
        end else if (wdata == KEY) begin
          open_q <= half_q;
          half_q <= ~half_q;
        end else begin
          half_q <= 1'b0;
        end
      end
      if (dat_wr) begin
        case (idx_q)
          8'h07: sel_q <= wdata;
          8'h30: if (sel_ok) act_q[ld] <= wdata[0];
          8'h60, 8'h61, 8'h62, 8'h63: if (sel_ok) base_q[ld][idx_q[1:0]] <= wdata;
          8'h70: if (sel_ok) irq_q[ld] <= wdata;
          8'h71: if (sel_ok) trig_q[ld] <= wdata;
          default: if (gp_hit) dir_q[gp_bit] <= wdata[0];
        endcase
      end
    end
  end

  p_locked_read_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !open_q |=> rdata == 8'hFF);

  p_exit_locks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    open_q && idx_wr && wdata == EXIT |=> !open_q);

  p_open_needs_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q && !(idx_wr && wdata == KEY) |=> !open_q);

  p_dir_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr_sel && open_q) |=> $stable(gpio_dir));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/tb_sio_cfg_port.sv
module tb_sio_cfg_port;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, addr_sel = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [10:0] gpio_dir;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  sio_cfg_port dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr_sel(addr_sel), .wdata(wdata), .rdata(rdata), .gpio_dir(gpio_dir));

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic we, input logic re, input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = we; rd_en = re; addr_sel = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wi(input logic [7:0] d); strobe(1'b1, 1'b0, 1'b0, d); endtask
  task automatic wd(input logic [7:0] d); strobe(1'b1, 1'b0, 1'b1, d); endtask
  task automatic rd(input logic a, output logic [7:0] v); strobe(1'b0, 1'b1, a, 8'h00); v = rdata; endtask
  task automatic wreg(input logic [7:0] r, input logic [7:0] d); wi(r); wd(d); endtask
  task automatic rreg(input logic [7:0] r, output logic [7:0] v); wi(r); rd(1'b1, v); endtask
  task automatic unlock(); wi(8'h87); wi(8'h87); endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 rdata after reset", {8'h0, rdata}, 16'h00FF);
    check("R1 gpio_dir after reset", {5'h0, gpio_dir}, 16'h07FF);
    rd(1'b1, v);
    check("R1 locked data read", {8'h0, v}, 16'h00FF);
    unlock();
    for (int d = 0; d < 9; d++) begin
      wreg(8'h07, 8'(d));
      rreg(8'h30, v);
      check("R1 device inactive", {8'h0, v}, 16'h0000);
    end
    wi(8'hAA);
  endtask

  task automatic t_unlock();
    logic [7:0] v;
    wi(8'h87);
    rd(1'b1, v);
    check("R2 one key keeps lock", {8'h0, v}, 16'h00FF);
    wi(8'h87);
    wreg(8'h07, 8'h03);
    rreg(8'h07, v);
    check("R2 open after two keys", {8'h0, v}, 16'h0003);
    wi(8'hAA);
  endtask

  task automatic t_restart();
    logic [7:0] v;
    wi(8'h87); wi(8'h55); wi(8'h87);
    rd(1'b0, v);
    check("R3 interrupted key stays locked", {8'h0, v}, 16'h00FF);
    wi(8'h87);
    rd(1'b0, v);
    check("R3 open after fresh pair", {8'h0, v}, 16'h0007);
    wi(8'hAA);
  endtask

  task automatic t_exit_and_locked();
    logic [7:0] v;
    unlock();
    wreg(8'h07, 8'h02);
    wi(8'h07);
    wi(8'hAA);
    rd(1'b0, v);
    check("R4 exit locks index port", {8'h0, v}, 16'h00FF);
    wd(8'h05);
    rd(1'b1, v);
    check("R5 locked data read", {8'h0, v}, 16'h00FF);
    unlock();
    rd(1'b0, v);
    check("R4 index kept over exit", {8'h0, v}, 16'h0007);
    rd(1'b1, v);
    check("R5 locked write ignored", {8'h0, v}, 16'h0002);
    wi(8'hAA);
  endtask

  task automatic t_banks();
    logic [7:0] v;
    unlock();
    wreg(8'h07, 8'h01); wreg(8'h30, 8'hFF); wreg(8'h70, 8'h03);
    wreg(8'h07, 8'h05); wreg(8'h30, 8'h00); wreg(8'h70, 8'h0C);
    wreg(8'h07, 8'h01);
    rreg(8'h30, v); check("R7 activate bit only", {8'h0, v}, 16'h0001);
    rreg(8'h70, v); check("R6 bank 1 irq", {8'h0, v}, 16'h0003);
    wreg(8'h07, 8'h05);
    rreg(8'h30, v); check("R7 deactivate", {8'h0, v}, 16'h0000);
    rreg(8'h70, v); check("R6 bank 5 irq", {8'h0, v}, 16'h000C);
    wreg(8'h07, 8'h09); wreg(8'h70, 8'h0E);
    rreg(8'h70, v); check("R6 absent bank reads zero", {8'h0, v}, 16'h0000);
    wreg(8'h07, 8'h05);
    rreg(8'h70, v); check("R6 absent bank write ignored", {8'h0, v}, 16'h000C);
    wi(8'hAA);
  endtask

  task automatic t_base_irq();
    logic [7:0] h, l;
    unlock();
    wreg(8'h07, 8'h06);
    wreg(8'h60, 8'h01); wreg(8'h61, 8'h80);
    wreg(8'h62, 8'h03); wreg(8'h63, 8'h3A);
    rreg(8'h60, h); rreg(8'h61, l);
    check("R8 base 0", {h, l}, 16'h0180);
    rreg(8'h62, h); rreg(8'h63, l);
    check("R8 base 1", {h, l}, 16'h033A);
    wreg(8'h70, 8'h06); wreg(8'h71, 8'h02);
    rreg(8'h70, h); rreg(8'h71, l);
    check("R9 irq and trigger", {h, l}, 16'h0602);
    wi(8'hAA);
  endtask

  task automatic t_gpio();
    logic [7:0]  v;
    logic [10:0] exp = 11'h7FF;
    unlock();
    wreg(8'h07, 8'h07);
    wreg(8'hE1, 8'h00); exp[0] = 1'b0;
    wreg(8'hE7, 8'h00); exp[6] = 1'b0;
    wreg(8'hE2, 8'hFE); exp[1] = 1'b0;
    wreg(8'hE8, 8'h00);
    check("R10 device 7 pins", {5'h0, gpio_dir}, {5'h0, exp});
    rreg(8'hE2, v); check("R10 readback output", {8'h0, v}, 16'h0000);
    rreg(8'hE3, v); check("R10 readback input", {8'h0, v}, 16'h0001);
    wreg(8'h07, 8'h08);
    wreg(8'hE8, 8'h00); exp[7] = 1'b0;
    wreg(8'hEB, 8'h00); exp[10] = 1'b0;
    wreg(8'hEC, 8'h00);
    wreg(8'hE1, 8'h00);
    check("R10 device 8 pins", {5'h0, gpio_dir}, {5'h0, exp});
    rreg(8'hEC, v); check("R10 unimplemented reads zero", {8'h0, v}, 16'h0000);
    wreg(8'h07, 8'h03); wreg(8'hE5, 8'h00);
    check("R10 other device no effect", {5'h0, gpio_dir}, {5'h0, exp});
    wreg(8'h07, 8'h07); wreg(8'hE1, 8'h01); exp[0] = 1'b1;
    check("R10 back to input", {5'h0, gpio_dir}, {5'h0, exp});
    wi(8'hAA);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    unlock();
    wreg(8'h07, 8'h01);
    wi(8'h70);
    strobe(1'b1, 1'b1, 1'b1, 8'h0B);
    check("R11 read sees old value", {8'h0, rdata}, 16'h0003);
    repeat (2) @(negedge clk);
    check("R11 rdata holds", {8'h0, rdata}, 16'h0003);
    rd(1'b1, v);
    check("R11 write landed", {8'h0, v}, 16'h000B);
    rd(1'b0, v);
    check("R12 index read", {8'h0, v}, 16'h0070);
    strobe(1'b1, 1'b1, 1'b0, 8'hAA);
    check("R11 exit with read sees index", {8'h0, rdata}, 16'h0070);
    rd(1'b0, v);
    check("R4 locked after exit", {8'h0, v}, 16'h00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlock();
    t_restart();
    t_exit_and_locked();
    t_banks();
    t_base_irq();
    t_gpio();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule